// File: doc/BRIEF.md
# Virtual Interrupt Priority Register File

This block holds the hypervisor's controls for the interrupts a guest supervisor sees. It has a control register and a table of 64 eight-bit priorities. Software reaches the table through four window registers. Each window packs a run of consecutive table entries into one data word, one byte per entry. The block decodes single-cycle CSR requests for its own five registers. It returns read data and a 2-bit fault code in the same cycle, and a write commits at the next clock edge.

The block also watches guest accesses to the supervisor interrupt-enable and interrupt-pending registers. It does not hold those registers. While virtualization is on and the control register's trap bit is set, it turns any such access into a virtual-instruction fault. With XLEN of 32 all four windows are usable. With XLEN of 64 each window carries eight bytes and the two upper-half windows fault.

Top module: `vprio_csr`

## Requirements
- R1: After reset the control register and every priority entry read as zero.
- R2: A control register write stores the write data ANDed with CTL_MASK (default 0x4000_0FFF). Reads return the stored value.
- R3: Window addresses are 0x611, 0x612, 0x613 and 0x614. They start at table indices 0, 4, 8 and 12 respectively, and the control register is at 0x610. A window holds XLEN/8 bytes, and byte i in bits [8i+7:8i] is entry start+i.
- R4: Read data and fault code are valid in the cycle of the request. An accepted write is visible to the next request.
- R5: Read-zero slots (default index 0) always read 0 in their lane. A write forces the entry to 0 and ignores the written byte.
- R6: Invalid slots (default index 9) read 0. Writes to them change nothing.
- R7: With XLEN of 64 the upper-half windows 0x612 and 0x614 give an illegal fault, whatever the virtualization state.
- R8: While feat_en is low, every access to the five own registers gives an illegal fault and changes no state.
- R9: An access to an own register with hmode_ok low faults and changes no state. The fault is virtual when virt_on is high and illegal otherwise.
- R10: Under three conditions together (virt_on high, control bit 30 set, request to 0x120 or 0x121) the fault is virtual. In every other case such a request gets fault none.
- R11: Fault codes are 0 none, 1 illegal and 2 virtual, and 3 never appears. A faulting request returns read data 0. rsp_hit is high only for a valid request to an own register. An idle or unmapped request returns zero data and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Advanced interrupt feature present |
| hmode_ok | input | 1 | Requester holds hypervisor permission |
| virt_on | input | 1 | Virtualization mode active |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | CSR address |
| req_wdata | input | XLEN | Write data |
| rsp_rdata | output | XLEN | Read data, same cycle |
| rsp_fault | output | 2 | Fault code |
| rsp_hit | output | 1 | Request targets an own register |

## Verification
The trap gate on the interrupt-enable and interrupt-pending registers reads the stored control value. A control write commits on the same edge that ends its request. The bench drives a control write and a guest interrupt-enable or interrupt-pending access in back-to-back cycles, with no idle cycle between them. It checks that the fault code of the second access follows the newly written trap bit in both directions. It also runs faulting writes and checks through later reads that nothing was stored.

// File: rtl/vprio_csr.sv
module vprio_csr #(
  parameter int          XLEN         = 32,
  parameter int          NPRIO        = 64,
  parameter int          VTI_BIT      = 30,
  parameter logic [63:0] CTL_MASK     = 64'h0000_0000_4000_0FFF,
  parameter logic [31:0] RDZERO_MASK  = 32'h0000_0001,
  parameter logic [31:0] INVALID_MASK = 32'h0000_0200,
  parameter logic [11:0] A_CTL        = 12'h610,
  parameter logic [11:0] A_W1         = 12'h611,
  parameter logic [11:0] A_W1H        = 12'h612,
  parameter logic [11:0] A_W2         = 12'h613,
  parameter logic [11:0] A_W2H        = 12'h614,
  parameter logic [11:0] A_SIE        = 12'h120,
  parameter logic [11:0] A_SIP        = 12'h121
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            feat_en,
  input  logic            hmode_ok,
  input  logic            virt_on,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [11:0]     req_addr,
  input  logic [XLEN-1:0] req_wdata,
  output logic [XLEN-1:0] rsp_rdata,
  output logic [1:0]      rsp_fault,
  output logic            rsp_hit
);
  localparam int         NB     = XLEN / 8;
  localparam int         IW     = $clog2(NPRIO);
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_ILL  = 2'd1;
  localparam logic [1:0] F_VIRT = 2'd2;

  logic [XLEN-1:0] ctl_q;
  logic [7:0]      prio_q [NPRIO];

  logic            is_ctl, is_win, is_gate, upper, wr_ok;
  logic [1:0]      wsel;
  logic [4:0]      base;
  logic [NB-1:0][4:0] lidx;
  logic [NB-1:0]   lrz, linv;
  logic [XLEN-1:0] win_rd;

  assign is_ctl  = req_addr == A_CTL;
  assign is_gate = (req_addr == A_SIE) || (req_addr == A_SIP);

  always_comb begin
    is_win = 1'b1;
    wsel   = 2'd0;
    if      (req_addr == A_W1)  wsel = 2'd0;
    else if (req_addr == A_W1H) wsel = 2'd1;
    else if (req_addr == A_W2)  wsel = 2'd2;
    else if (req_addr == A_W2H) wsel = 2'd3;
    else                        is_win = 1'b0;
  end

  assign upper = wsel[0];
  assign base  = {1'b0, wsel, 2'b00};

  always_comb begin
    rsp_fault = F_NONE;
    if (req_valid) begin
      if (is_ctl || is_win) begin
        if (!feat_en)                          rsp_fault = F_ILL;
        else if (is_win && upper && XLEN != 32) rsp_fault = F_ILL;
        else if (!hmode_ok)                    rsp_fault = virt_on ? F_VIRT : F_ILL;
      end else if (is_gate && virt_on && ctl_q[VTI_BIT]) begin
        rsp_fault = F_VIRT;
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lidx[g] = base + 5'(g);
    assign lrz[g]  = RDZERO_MASK[lidx[g]];
    assign linv[g] = INVALID_MASK[lidx[g]];
    assign win_rd[8*g +: 8] = (lrz[g] || linv[g]) ? 8'h00 : prio_q[IW'(lidx[g])];
  end

  assign wr_ok   = req_valid && req_we && (rsp_fault == F_NONE);
  assign rsp_hit = req_valid && (is_ctl || is_win);

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && rsp_fault == F_NONE) begin
      if (is_ctl)      rsp_rdata = ctl_q;
      else if (is_win) rsp_rdata = win_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      for (int i = 0; i < NPRIO; i++) prio_q[i] <= 8'h00;
    end else if (wr_ok) begin
      if (is_ctl) ctl_q <= req_wdata & CTL_MASK[XLEN-1:0];
      if (is_win) begin
        for (int i = 0; i < NB; i++) begin
          if (!linv[i]) prio_q[IW'(lidx[i])] <= lrz[i] ? 8'h00 : req_wdata[8*i +: 8];
        end
      end
    end
  end
endmodule

module vprio_csr_chk #(
  parameter int          XLEN     = 32,
  parameter int          VTI_BIT  = 30,
  parameter logic [63:0] CTL_MASK = 64'h0,
  parameter logic [11:0] A_CTL    = 12'h610,
  parameter logic [11:0] A_SIE    = 12'h120,
  parameter logic [11:0] A_SIP    = 12'h121
)(
  input logic            clk,
  input logic            rst_n,
  input logic            feat_en,
  input logic            virt_on,
  input logic            req_valid,
  input logic            req_we,
  input logic [11:0]     req_addr,
  input logic [XLEN-1:0] req_wdata,
  input logic [XLEN-1:0] rsp_rdata,
  input logic [1:0]      rsp_fault,
  input logic [XLEN-1:0] ctl_q
);
  p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'd3);

  p_fault_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'd0 |-> rsp_rdata == '0);

  p_nofeat_ill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !feat_en && req_addr == A_CTL |-> rsp_fault == 2'd1);

  p_fault_holds_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_fault != 2'd0 |=> $stable(ctl_q));

  p_ctl_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && req_addr == A_CTL && rsp_fault == 2'd0
    |=> ctl_q == ($past(req_wdata) & CTL_MASK[XLEN-1:0]));

  p_vti_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && virt_on && ctl_q[VTI_BIT] && (req_addr == A_SIE || req_addr == A_SIP)
    |-> rsp_fault == 2'd2);
endmodule

bind vprio_csr vprio_csr_chk #(
  .XLEN(XLEN), .VTI_BIT(VTI_BIT), .CTL_MASK(CTL_MASK),
  .A_CTL(A_CTL), .A_SIE(A_SIE), .A_SIP(A_SIP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .virt_on(virt_on),
  .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
  .ctl_q(ctl_q)
);

// File: tb/vprio_csr_bench.sv
module vprio_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b1, hmode_ok = 1'b1, virt_on = 1'b0;
  logic        v32 = 1'b0, v64 = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wd = '0;
  logic [31:0] rd32;
  logic [63:0] rd64;
  logic [1:0]  f32, f64;
  logic        h32, h64;
  logic [63:0] rd;
  logic [1:0]  f;
  logic        hit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vprio_csr #(.XLEN(32)) u_vprio_csr (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .hmode_ok(hmode_ok), .virt_on(virt_on),
    .req_valid(v32), .req_we(we), .req_addr(addr), .req_wdata(wd[31:0]),
    .rsp_rdata(rd32), .rsp_fault(f32), .rsp_hit(h32));

  vprio_csr #(.XLEN(64)) u_vprio_csr_w64 (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .hmode_ok(hmode_ok), .virt_on(virt_on),
    .req_valid(v64), .req_we(we), .req_addr(addr), .req_wdata(wd),
    .rsp_rdata(rd64), .rsp_fault(f64), .rsp_hit(h64));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input bit w64, input bit wr, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    we = wr; addr = a; wd = d;
    if (w64) v64 = 1'b1; else v32 = 1'b1;
    #1;
    rd  = w64 ? rd64 : {32'h0, rd32};
    f   = w64 ? f64 : f32;
    hit = w64 ? h64 : h32;
    @(posedge clk); #1;
    v32 = 1'b0; v64 = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset;
    acc(0, 0, 12'h610, 0); chk("R1 ctl after reset", rd, 0); chk("R1 fault", f, 0);
    acc(0, 0, 12'h612, 0); chk("R1 window after reset", rd, 0);
    acc(1, 0, 12'h613, 0); chk("R1 w64 window after reset", rd, 0);
  endtask

  task automatic t_ctl_mask;
    acc(0, 1, 12'h610, 64'hFFFF_FFFF); chk("R2 write fault", f, 0); chk("R11 hit", hit, 1);
    acc(0, 0, 12'h610, 0); chk("R2 R4 masked ctl", rd, 64'h4000_0FFF);
  endtask

  task automatic t_windows32;
    acc(0, 1, 12'h611, 64'h4433_2211); acc(0, 0, 12'h611, 0);
    chk("R3 R5 window1 read-zero lane", rd, 64'h4433_2200);
    acc(0, 1, 12'h612, 64'h8877_6655); acc(0, 0, 12'h612, 0);
    chk("R3 window1 upper", rd, 64'h8877_6655);
    acc(0, 1, 12'h613, 64'hDDCC_BBAA); acc(0, 0, 12'h613, 0);
    chk("R6 window2 invalid lane", rd, 64'hDDCC_00AA);
    acc(0, 1, 12'h614, 64'h0102_0304); acc(0, 0, 12'h614, 0);
    chk("R3 window2 upper", rd, 64'h0102_0304);
    acc(0, 0, 12'h611, 0); chk("R3 window1 unchanged", rd, 64'h4433_2200);
  endtask

  task automatic t_windows64;
    acc(1, 1, 12'h611, 64'h8877_6655_4433_2211); acc(1, 0, 12'h611, 0);
    chk("R3 R5 w64 window1", rd, 64'h8877_6655_4433_2200);
    acc(1, 1, 12'h613, 64'h1122_3344_5566_7788); acc(1, 0, 12'h613, 0);
    chk("R3 R6 w64 window2", rd, 64'h1122_3344_5566_0088);
    acc(1, 0, 12'h612, 0); chk("R7 w64 upper illegal", f, 1); chk("R11 faulted data", rd, 0);
    virt_on = 1'b1;
    acc(1, 1, 12'h614, 64'hFFFF); chk("R7 w64 upper illegal virt", f, 1);
    virt_on = 1'b0;
    acc(1, 0, 12'h613, 0); chk("R7 w64 window2 intact", rd, 64'h1122_3344_5566_0088);
  endtask

  task automatic t_feature;
    feat_en = 1'b0;
    acc(0, 1, 12'h610, 0); chk("R8 ctl illegal", f, 1); chk("R8 hit", hit, 1);
    acc(0, 1, 12'h614, 64'hFFFF_FFFF); chk("R8 window illegal", f, 1);
    feat_en = 1'b1;
    acc(0, 0, 12'h610, 0); chk("R8 ctl unchanged", rd, 64'h4000_0FFF);
    acc(0, 0, 12'h614, 0); chk("R8 window unchanged", rd, 64'h0102_0304);
  endtask

  task automatic t_hmode;
    hmode_ok = 1'b0;
    acc(0, 1, 12'h610, 0); chk("R9 illegal off-virt", f, 1);
    virt_on = 1'b1;
    acc(0, 1, 12'h610, 0); chk("R9 virtual in-virt", f, 2);
    acc(0, 0, 12'h613, 0); chk("R9 window virtual", f, 2); chk("R11 faulted data", rd, 0);
    hmode_ok = 1'b1; virt_on = 1'b0;
    acc(0, 0, 12'h610, 0); chk("R9 ctl unchanged", rd, 64'h4000_0FFF);
  endtask

  task automatic t_vti;
    virt_on = 1'b1;
    acc(0, 0, 12'h120, 0); chk("R10 sie trapped", f, 2); chk("R11 gate not hit", hit, 0);
    acc(0, 1, 12'h121, 64'h1); chk("R10 sip trapped", f, 2);
    virt_on = 1'b0;
    acc(0, 0, 12'h120, 0); chk("R10 no virt no trap", f, 0);
  endtask

  task automatic t_back_to_back;
    virt_on = 1'b1;
    @(negedge clk); v32 = 1'b1; we = 1'b1; addr = 12'h610; wd = 0;
    @(negedge clk); we = 1'b0; addr = 12'h120;
    #1; chk("R10 R4 trap cleared next cycle", f32, 0);
    @(posedge clk); #1; v32 = 1'b0;
    @(negedge clk); v32 = 1'b1; we = 1'b1; addr = 12'h610; wd = 64'h4000_0000;
    @(negedge clk); we = 1'b0; addr = 12'h121;
    #1; chk("R10 R4 trap set next cycle", f32, 2);
    @(posedge clk); #1; v32 = 1'b0; virt_on = 1'b0;
  endtask

  task automatic t_unmapped;
    acc(0, 1, 12'h7FF, 64'hFFFF); chk("R11 unmapped hit", hit, 0);
    chk("R11 unmapped fault", f, 0); chk("R11 unmapped data", rd, 0);
    @(negedge clk); #1;
    chk("R11 idle data", rd32, 0); chk("R11 idle fault", f32, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctl_mask;
    t_windows32;
    t_windows64;
    t_feature;
    t_hmode;
    t_vti;
    t_back_to_back;
    t_unmapped;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule